// File: doc/BRIEF.md
# Interleaved Sixteen-Bank Byte Memory

This block is a 32K-byte memory made of sixteen separate byte-wide banks of 2K entries each. It has one address port, one write-data port and one read-data port. A flat 15-bit byte address is split into a 4-bit bank field and an 11-bit offset field. The decoded bank field raises one enable line, and the offset indexes the entry inside that bank. Writes take effect on the rising clock edge. Reads are combinational.

A single mode input picks where the bank field sits in the address. In low-order mode the bank field is the bottom four bits, so neighbouring addresses land in neighbouring banks, which lets sequential streams spread across all sixteen arrays. In high-order mode the bank field is the top four bits, so each bank holds one contiguous 2K window.

The mode is a static setting. Changing it while data is stored only changes how addresses are interpreted; no byte moves. The same bank field drives both the enable decoder and the read multiplexer, so a read always returns the entry of the bank that would have been written. While reset is held low, writes are blocked.

Top module: `ilv_byte_mem`

## Requirements
- R1: With `hi_order` = 0, the bank is `addr[3:0]`, the offset is `addr[14:4]`, and `bank_en` has only bit `addr[3:0]` set.
- R2: With `hi_order` = 1, the bank is `addr[14:11]`, the offset is `addr[10:0]`, and `bank_en` has only bit `addr[14:11]` set.
- R3: `bank_en` has exactly one bit set in every cycle, including during reset.
- R4: With `rst_n` = 1 and `wr_en` = 1 at a rising edge, `wr_data` is stored at the addressed bank and offset. It is returned by a later read of the same address in the same mode.
- R5: `rd_data` follows a change of `addr` within the same clock phase, with no clock edge in between.
- R6: A rising edge with `wr_en` = 0 leaves every stored byte unchanged.
- R7: A write changes only the one addressed location. When every address is written with its own pattern, each address reads back its own pattern afterwards.
- R8: Switching `hi_order` moves no data. The byte written at low-order address A is read in high-order mode at `{A[3:0], A[14:4]}`. The byte written at high-order address H is read in low-order mode at `{H[10:0], H[14:11]}`.
- R9: While `rst_n` = 0, a rising edge with `wr_en` = 1 does not change the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| hi_order | input | 1 | Mapping mode: 0 = bank in low address bits, 1 = bank in high address bits |
| addr | input | 15 | Flat byte address |
| wr_en | input | 1 | Write request for the addressed byte |
| wr_data | input | 8 | Byte to be written |
| rd_data | output | 8 | Byte at the addressed location (combinational) |
| bank_en | output | 16 | One-hot enable of the bank the address maps to |

## Verification
The bound checker checks on every cycle the properties that hold at the ports in every cycle:
- `bank_en` is one-hot, with the set bit taken from the low address bits in one mode and the high bits in the other;
- a write followed by a read of the same address returns the written byte;
- a cycle without a write leaves the read value of an unchanged address steady.

Other behaviours cover the whole storage array at once, or span several cycles of history, and only the bench scenarios can show them:
- every location keeps its own pattern after a full low-order fill;
- data written in one mode appears at the remapped address in the other;
- writes attempted during reset leave no trace.

// File: rtl/ilvm_pkg.sv
package ilvm_pkg;

    // Where the bank field sits inside the flat address
    typedef enum logic {
        MAP_LOW  = 1'b0,
        MAP_HIGH = 1'b1
    } map_mode_e;

endpackage

// File: rtl/ilvm_addr_split.sv
module ilvm_addr_split
    import ilvm_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int OFFS_W = 11
) (
    input  map_mode_e                  mode,
    input  logic [BANK_W+OFFS_W-1:0]   addr,
    output logic [BANK_W-1:0]          bank,
    output logic [OFFS_W-1:0]          offs
);
    localparam int ADDR_W = BANK_W + OFFS_W;

    always_comb begin
        bank = addr[BANK_W-1:0];
        offs = addr[ADDR_W-1:BANK_W];
        unique case (mode)
            MAP_LOW: begin
                bank = addr[BANK_W-1:0];
                offs = addr[ADDR_W-1:BANK_W];
            end
            MAP_HIGH: begin
                bank = addr[ADDR_W-1:OFFS_W];
                offs = addr[OFFS_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/ilvm_bank_dec.sv
module ilvm_bank_dec #(
    parameter int BANK_W = 4,
    parameter int NBANK  = 1 << BANK_W
) (
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  en
);
    for (genvar i = 0; i < NBANK; i++) begin : g_line
        assign en[i] = (bank == BANK_W'(i));
    end

endmodule

// File: rtl/ilvm_byte_bank.sv
module ilvm_byte_bank #(
    parameter int OFFS_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [OFFS_W-1:0] offs,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << OFFS_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[offs] <= wd;
        end
    end

    assign rd = cells[offs];

endmodule

// File: rtl/ilv_byte_mem.sv
module ilv_byte_mem
    import ilvm_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int OFFS_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hi_order,
    input  logic [BANK_W+OFFS_W-1:0]    addr,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [DATA_W-1:0]           rd_data,
    output logic [(1<<BANK_W)-1:0]      bank_en
);
    localparam int NBANK = 1 << BANK_W;

    map_mode_e         mode;
    logic [BANK_W-1:0] bank_sel;
    logic [OFFS_W-1:0] bank_offs;
    logic              wr_ok;
    logic [DATA_W-1:0] bank_rd [NBANK];

    assign mode  = hi_order ? MAP_HIGH : MAP_LOW;
    assign wr_ok = wr_en & rst_n;

    ilvm_addr_split #(
        .BANK_W (BANK_W),
        .OFFS_W (OFFS_W)
    ) split_i (
        .mode (mode),
        .addr (addr),
        .bank (bank_sel),
        .offs (bank_offs)
    );

    ilvm_bank_dec #(
        .BANK_W (BANK_W),
        .NBANK  (NBANK)
    ) dec_i (
        .bank (bank_sel),
        .en   (bank_en)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ilvm_byte_bank #(
            .OFFS_W (OFFS_W),
            .DATA_W (DATA_W)
        ) bank_i (
            .clk  (clk),
            .we   (wr_ok & bank_en[b]),
            .offs (bank_offs),
            .wd   (wr_data),
            .rd   (bank_rd[b])
        );
    end

    // Read path uses the same bank field as the enable decoder
    assign rd_data = bank_rd[bank_sel];

endmodule

// File: rtl/ilv_byte_mem_chk.sv
module ilv_byte_mem_chk #(
    parameter int BANK_W = 4,
    parameter int OFFS_W = 11,
    parameter int DATA_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        hi_order,
    input logic [BANK_W+OFFS_W-1:0]    addr,
    input logic                        wr_en,
    input logic [DATA_W-1:0]           wr_data,
    input logic [DATA_W-1:0]           rd_data,
    input logic [(1<<BANK_W)-1:0]      bank_en
);
    localparam int ADDR_W = BANK_W + OFFS_W;
    localparam int NBANK  = 1 << BANK_W;

    logic [BANK_W-1:0] lo_field;
    logic [BANK_W-1:0] hi_field;
    logic [NBANK-1:0]  one;

    assign lo_field = addr[BANK_W-1:0];
    assign hi_field = addr[ADDR_W-1:OFFS_W];
    assign one      = {{(NBANK-1){1'b0}}, 1'b1};

    // R3
    onehot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_en) == 1);

    // R1
    low_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_order |-> bank_en == (one << lo_field));

    // R2
    high_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_order |-> bank_en == (one << hi_field));

    // R4
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((addr != $past(addr)) || (hi_order != $past(hi_order))
                   || (rd_data == $past(wr_data))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((addr != $past(addr)) || (hi_order != $past(hi_order))
                    || (rd_data == $past(rd_data))));

endmodule

bind ilv_byte_mem ilv_byte_mem_chk #(
    .BANK_W (BANK_W),
    .OFFS_W (OFFS_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_order (hi_order),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .bank_en  (bank_en)
);

// File: tb/ilv_byte_mem_tb_top.sv
module ilv_byte_mem_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_order = 1'b0;
    logic [14:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] bank_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ilv_byte_mem dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_order (hi_order),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .bank_en  (bank_en)
    );

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], 1'b1};
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wr_data = d;
        wr_en = 1'b1;
        @(posedge clk);
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0;
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        wr_en = 1'b0;
        hi_order = m;
    endtask

    // R3: one-hot enable while in reset
    task automatic t_reset_state();
        logic [14:0] a;
        a = 15'h5A3C;
        addr = a;
        repeat (3) @(posedge clk);
        #1;
        chk16("R3 reset enable", bank_en, 16'h1 << a[3:0]);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R4 R7: fill every address in low-order mode, then read all back
    task automatic t_sweep_low();
        logic [7:0] d;
        set_mode(1'b0);
        for (int i = 0; i < 32768; i++) begin
            logic [14:0] a;
            a = 15'(i);
            wr(a, pat(a));
            if (i % 97 == 0) chk16("R1 low enable", bank_en, 16'h1 << a[3:0]);
        end
        for (int i = 0; i < 32768; i++) begin
            logic [14:0] a;
            a = 15'(i);
            rd(a, d);
            chk8("R7 sweep readback", d, pat(a));
        end
    endtask

    // R8: high-order view of the low-order fill
    task automatic t_remap_to_high();
        logic [7:0] d;
        set_mode(1'b1);
        for (int i = 0; i < 4096; i++) begin
            logic [14:0] a;
            a = 15'(i * 7 + 3);
            rd({a[3:0], a[14:4]}, d);
            chk8("R8 low to high", d, pat(a));
        end
    endtask

    // R2 R4 R8: writes in high-order mode, seen in both modes
    task automatic t_high_writes();
        logic [7:0] d;
        logic [14:0] h;
        logic [14:0] nb;
        set_mode(1'b1);
        h = 15'h4803;
        wr(h, 8'hC5);
        #1;
        chk16("R2 high enable", bank_en, 16'h1 << h[14:11]);
        rd(h, d);
        chk8("R4 high readback", d, 8'hC5);
        nb = h + 15'd1;
        rd(nb, d);
        chk8("R7 neighbour kept", d, pat({nb[10:0], nb[14:11]}));
        wr(15'h7FFF, 8'h3E);
        #1;
        chk16("R2 top bank enable", bank_en, 16'h8000);
        wr(15'h0000, 8'h91);
        #1;
        chk16("R2 bottom bank enable", bank_en, 16'h0001);
        set_mode(1'b0);
        rd({h[10:0], h[14:11]}, d);
        chk8("R8 high to low", d, 8'hC5);
        rd(15'h7FFF, d);
        chk8("R8 high to low top", d, 8'h3E);
        rd(15'h0000, d);
        chk8("R8 high to low bottom", d, 8'h91);
    endtask

    // R6: idle edge leaves data untouched
    task automatic t_idle_hold();
        logic [7:0] d;
        set_mode(1'b0);
        wr(15'h1234, 8'h6D);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'hFF;
        repeat (3) @(posedge clk);
        rd(15'h1234, d);
        chk8("R6 no write", d, 8'h6D);
    endtask

    // R5: read follows address without a clock edge
    task automatic t_comb_read();
        wr(15'h0101, 8'hA1);
        wr(15'h0202, 8'hB2);
        @(negedge clk);
        wr_en = 1'b0;
        addr = 15'h0101;
        #1;
        chk8("R5 first addr", rd_data, 8'hA1);
        addr = 15'h0202;
        #1;
        chk8("R5 second addr", rd_data, 8'hB2);
    endtask

    // R9: writes blocked during reset
    task automatic t_reset_block();
        logic [7:0] d;
        wr(15'h0005, 8'h11);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1;
        addr = 15'h0005;
        wr_data = 8'hEE;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        rd(15'h0005, d);
        chk8("R9 reset blocks write", d, 8'h11);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_sweep_low();
        t_remap_to_high();
        t_high_writes();
        t_idle_hold();
        t_comb_read();
        t_reset_block();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule